// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block runs on the host side of a flash device after a program or erase command has been issued. It decides whether the embedded operation has finished by polling. A single-cycle start captures the address to poll, the byte that was written and an erase flag. The block then reads that address again and again through a synchronous request/acknowledge read port. On each read it compares the most significant bit with the expected value. When the bits differ, it looks at the time-limit flag in bit 5.

The most significant bit can turn to true data in the same read in which bit 5 rises. For that reason a raised limit flag is never taken as failure on its own: the block reads the address once more, and only a mismatch on that second read means failure. The low bits are not trusted on the read that first shows a matching top bit. After a match the block makes one further read and presents the whole byte on `result_o`, in the same cycle as the pass pulse. An optional budget of polling reads turns a stuck device into a failure.

Top module: `flash_poll_checker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o`, `rd_req_o`, `pass_o` and `fail_o` are 0 and `result_o` is 0.
- R2: A start seen while idle captures `addr_i`, and every read request of that run presents the captured address on `rd_addr_o`. A start seen while busy has no effect on the address, the reads or the result.
- R3: A polling read whose bit 7 equals the expected bit 7 ends polling with a pass decision.
- R4: A polling read whose bit 7 differs and whose bit 5 is 0 is followed by another polling read of the same address.
- R5: A polling read whose bit 7 differs and whose bit 5 is 1 is followed by exactly one recheck read. If bit 7 of the recheck read matches, the run passes; if it differs, `fail_o` pulses and no further read is made.
- R6: When `erase_i` is 1 at start, the expected bit 7 is 1 whatever `expect_i` holds. Otherwise it is `expect_i[7]`.
- R7: After a pass decision, exactly one more read is made. Its full 8-bit value appears on `result_o` in the cycle `pass_o` pulses and holds until the next pass.
- R8: With `MAX_POLLS` greater than 0, if `MAX_POLLS` polling reads each return bit 7 mismatching and bit 5 at 0, `fail_o` pulses after the last of them and no further read is made.
- R9: `pass_o` and `fail_o` are one cycle wide and never high together. `busy_o` is high from the cycle after an accepted start and is low in the cycle the result pulse appears.
- R10: `rd_req_o` stays high with a stable address until a cycle in which `rd_ack_i` is high. `rd_data_i` is sampled in that cycle, and a new request may follow in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a completion check (one cycle) |
| addr_i | input | ADDR_W | Address to poll |
| expect_i | input | 8 | Byte that was programmed |
| erase_i | input | 1 | 1 for an erase: expected bit 7 is forced to 1 |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read completed; data valid this cycle |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Check in progress |
| pass_o | output | 1 | One-cycle pulse: operation complete |
| fail_o | output | 1 | One-cycle pulse: operation failed |
| result_o | output | 8 | Byte from the confirming read after a pass |

## Verification
Two events can fall in the same read: the top bit turning to true data, and the time-limit flag rising. The bench provokes this in two ways. In one case a read shows bit 5 set with bit 7 still wrong and the recheck shows a match. In the other both reads are wrong. A pass is expected in the first case and a fail in the second, and the queue of returned bytes must be drained exactly. A per-cycle behavioural model also covers an immediate match, long mismatch runs, erase polarity, the polling budget, stalled acknowledges and a start raised mid-run.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POLL,
        ST_RECHECK,
        ST_CONFIRM
    } poll_state_e;
endpackage

// File: rtl/poll_bit_judge.sv
// Decodes one returned byte against the expected top bit.
module poll_bit_judge #(
    parameter int DATA_W   = 8,
    parameter int FLAG_BIT = 5
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              exp_msb_i,
    output logic              hit_o,
    output logic              limit_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        hit_o   = (data_i[MSB] == exp_msb_i);
        limit_o = data_i[FLAG_BIT];
    end
endmodule

// File: rtl/poll_budget.sv
// Counts polling reads; reports when the current read is the last allowed.
module poll_budget #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic exhausted_o
);
    generate
        if (MAX_POLLS > 0) begin : g_limited
            localparam int CNT_W = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clear_i) begin
                    cnt_d = '0;
                end else if (step_i && (cnt_q != LAST)) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign exhausted_o = (cnt_q == LAST);
        end else begin : g_unlimited
            logic unused_ok;
            assign unused_ok   = clk ^ rst_n ^ clear_i ^ step_i;
            assign exhausted_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        expect_i,
    input  logic              erase_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    output logic              busy_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [7:0]        result_o
);
    localparam int DATA_W   = 8;
    localparam int MSB      = DATA_W - 1;
    localparam int FLAG_BIT = 5;

    typedef struct packed {
        poll_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic              exp_msb;
        logic              pass;
        logic              fail;
        logic [DATA_W-1:0] result;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic hit, limit_flag, exhausted;
    logic cnt_clear_d, cnt_step_d;

    poll_bit_judge #(
        .DATA_W   (DATA_W),
        .FLAG_BIT (FLAG_BIT)
    ) u_judge (
        .data_i    (rd_data_i),
        .exp_msb_i (ctl_q.exp_msb),
        .hit_o     (hit),
        .limit_o   (limit_flag)
    );

    poll_budget #(
        .MAX_POLLS (MAX_POLLS)
    ) u_budget (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (cnt_clear_d),
        .step_i      (cnt_step_d),
        .exhausted_o (exhausted)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pass  = 1'b0;
        ctl_d.fail  = 1'b0;
        cnt_clear_d = 1'b0;
        cnt_step_d  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state   = ST_POLL;
                    ctl_d.addr    = addr_i;
                    ctl_d.exp_msb = erase_i ? 1'b1 : expect_i[MSB];
                    cnt_clear_d   = 1'b1;
                end
            end
            ST_POLL: begin
                if (rd_ack_i) begin
                    if (hit) begin
                        ctl_d.state = ST_CONFIRM;
                    end else if (limit_flag) begin
                        ctl_d.state = ST_RECHECK;
                    end else begin
                        cnt_step_d = 1'b1;
                        if (exhausted) begin
                            ctl_d.state = ST_IDLE;
                            ctl_d.fail  = 1'b1;
                        end
                    end
                end
            end
            ST_RECHECK: begin
                if (rd_ack_i) begin
                    if (hit) begin
                        ctl_d.state = ST_CONFIRM;
                    end else begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.fail  = 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (rd_ack_i) begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.result = rd_data_i;
                    ctl_d.pass   = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, addr: '0, exp_msb: 1'b0,
                       pass: 1'b0, fail: 1'b0, result: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req_o  = (ctl_q.state != ST_IDLE);
    assign busy_o    = (ctl_q.state != ST_IDLE);
    assign rd_addr_o = ctl_q.addr;
    assign pass_o    = ctl_q.pass;
    assign fail_o    = ctl_q.fail;
    assign result_o  = ctl_q.result;
endmodule

// File: rtl/flash_poll_props.sv
module flash_poll_props #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              busy_o,
    input logic              pass_o,
    input logic              fail_o,
    input logic [7:0]        result_o
);
    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    assert_pass_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |=> !pass_o);

    assert_fail_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);

    assert_idle_on_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || fail_o) |-> !busy_o);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    assert_addr_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(rd_addr_o)));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_o |-> $stable(result_o));
endmodule

bind flash_poll_checker flash_poll_props #(.ADDR_W(ADDR_W)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .busy_o    (busy_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .result_o  (result_o)
);

// File: tb/flash_poll_checker_bench.sv
`timescale 1ns/1ps
module flash_poll_checker_bench;
    localparam int AW    = 20;
    localparam int LIMIT = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    expect_i = '0;
    logic          erase_i = 1'b0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          busy_o, pass_o, fail_o;
    logic [7:0]    result_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_poll_checker #(.ADDR_W(AW), .MAX_POLLS(LIMIT)) u_flash_poll_checker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .expect_i(expect_i), .erase_i(erase_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .pass_o(pass_o), .fail_o(fail_o), .result_o(result_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flash responder: bytes to return, stall cycles before each acknowledge
    logic [7:0] rsp_q[$];
    int stall = 0;
    int wait_cnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_o) begin
                if (wait_cnt >= stall) begin
                    rd_ack_i  = 1'b1;
                    rd_data_i = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'hEE;
                    wait_cnt  = 0;
                end else begin
                    rd_ack_i = 1'b0;
                    wait_cnt++;
                end
            end else begin
                rd_ack_i = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    // Behavioural reference: mode 0 idle, 1 polling, 2 one more look, 3 fetch result
    int          m_mode = 0;
    int          m_reads = 0;
    logic [AW-1:0] m_addr = '0;
    logic        m_want = 1'b0;
    logic        m_pass = 1'b0, m_fail = 1'b0;
    logic [7:0]  m_res = '0;
    always @(posedge clk) begin
        m_pass = 1'b0;
        m_fail = 1'b0;
        if (!rst_n) begin
            m_mode = 0; m_addr = '0; m_res = '0; m_reads = 0;
        end else if (m_mode == 0) begin
            if (start_i) begin
                m_mode = 1; m_addr = addr_i; m_reads = 0;
                m_want = erase_i ? 1'b1 : expect_i[7];
            end
        end else if (rd_ack_i) begin
            if (m_mode == 3) begin
                m_res = rd_data_i; m_pass = 1'b1; m_mode = 0;
            end else if (rd_data_i[7] == m_want) begin
                m_mode = 3;
            end else if (m_mode == 2) begin
                m_fail = 1'b1; m_mode = 0;
            end else if (rd_data_i[5]) begin
                m_mode = 2;
            end else begin
                m_reads++;
                if (m_reads >= LIMIT) begin
                    m_fail = 1'b1; m_mode = 0;
                end
            end
        end
    end

    logic cmp_en = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (cmp_en) begin
                chk("R9 busy vs model", busy_o, m_mode != 0);
                chk("R10 request vs model", rd_req_o, m_mode != 0);
                chk("R3 pass vs model", pass_o, m_pass);
                chk("R5 fail vs model", fail_o, m_fail);
                chk("R7 result vs model", result_o, m_res);
                if (m_mode != 0) chk("R2 read address vs model", rd_addr_o, m_addr);
            end
        end
    end

    task automatic run_op(input string tag, input logic [AW-1:0] a, input logic [7:0] e,
                          input logic er, input int st, input logic exp_pass,
                          input logic [7:0] exp_res, input logic kick);
        int n;
        stall = st;
        @(negedge clk);
        addr_i = a; expect_i = e; erase_i = er; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R9 busy after start"}, busy_o, 1'b1);
        n = 0;
        while (busy_o && n < 2000) begin
            @(negedge clk);
            n++;
            if (kick && n == 2) begin
                start_i = 1'b1; addr_i = ~a; expect_i = ~e; erase_i = ~er;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        chk({tag, " R3/R5 pass outcome"}, pass_o, exp_pass);
        chk({tag, " R5/R8 fail outcome"}, fail_o, !exp_pass);
        if (exp_pass) chk({tag, " R7 result byte"}, result_o, exp_res);
        @(negedge clk);
        chk({tag, " R9 pulse one cycle"}, pass_o | fail_o, 1'b0);
        chk({tag, " R4/R5 read count drained"}, rsp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy_o, 1'b0);
        chk("R1 request in reset", rd_req_o, 1'b0);
        chk("R1 pulses in reset", {pass_o, fail_o}, 2'b00);
        chk("R1 result in reset", result_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        chk("R1 idle after reset", busy_o, 1'b0);

        // R3, R7: immediate match then confirming read
        rsp_q = '{8'hA5, 8'hA5};
        run_op("R3 immediate", 20'h12345, 8'hA5, 1'b0, 0, 1'b1, 8'hA5, 1'b0);
        // R4: two mismatches with bit 5 clear, stalled acks (R10)
        rsp_q = '{8'hC3, 8'hC3, 8'h3C, 8'h3C};
        run_op("R4 R10 stalled", 20'h00F0F, 8'h3C, 1'b0, 2, 1'b1, 8'h3C, 1'b0);
        // R6: erase, expect_i says 0 but bit 7 must read 1
        rsp_q = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        run_op("R6 erase", 20'hABCDE, 8'h00, 1'b1, 0, 1'b1, 8'hFF, 1'b0);
        // R5: limit flag with recheck that matches
        rsp_q = '{8'hA0, 8'h55, 8'h55};
        run_op("R5 recheck pass", 20'h00001, 8'h55, 1'b0, 1, 1'b1, 8'h55, 1'b0);
        // R5: limit flag with recheck that still mismatches
        rsp_q = '{8'hA0, 8'hA0};
        run_op("R5 recheck fail", 20'h00002, 8'h55, 1'b0, 0, 1'b0, 8'h00, 1'b0);
        // R8: budget runs out
        rsp_q = {};
        for (int i = 0; i < LIMIT; i++) rsp_q.push_back(8'h80);
        run_op("R8 budget", 20'h00003, 8'h00, 1'b0, 0, 1'b0, 8'h00, 1'b0);
        // R2: start while busy ignored (stalled so the run is long)
        rsp_q = '{8'h00, 8'h00, 8'h11, 8'h91, 8'h93};
        run_op("R2 busy start", 20'h5A5A5, 8'h93, 1'b0, 1, 1'b1, 8'h93, 1'b1);

        cmp_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule